// File: doc/BRIEF.md
# Program Memory Byte Fetch Unit

This unit reads one byte out of a program memory that is organised as 16-bit words. A byte pointer (a 16-bit low pointer plus an optional page extension register) is split into a word address and a byte lane select. The unit issues a single-cycle read to a synchronous memory with one cycle of read latency. It then returns the chosen byte together with a one-cycle valid strobe.

In plain mode only the 16-bit low pointer is used, so the reachable range is 64 KB and the page bits of the address are forced to zero. In extended mode the page register sits above the low pointer, which opens up the whole memory. The operation can optionally advance the pointer by one byte afterwards. In extended mode that advance spans the page register, so the page and low pointer behave as one wide pointer. The advanced values are presented for the processor to write back.

Top module: `prog_byte_fetch`

## Requirements
- R1: One cycle after an accepted start, `mem_rd_o` is high for exactly one cycle and `mem_addr_o[14:0]` equals pointer bits [15:1]; the address holds its value while the result is valid.
- R2: Pointer bit 0 selects the byte lane: 0 returns word bits [7:0], 1 returns word bits [15:8].
- R3: In plain mode (`ext_mode_i`=0), `mem_addr_o[22:15]` is zero whatever the page input holds.
- R4: In extended mode (`ext_mode_i`=1), `mem_addr_o[22:15]` equals the page input.
- R5: Plain mode with post-increment returns low pointer + 1 modulo 2^16, and the page output equals the page input (no carry into it).
- R6: Extended mode with post-increment returns {page, low pointer} + 1 modulo 2^24, so a carry out of the low pointer increments the page.
- R7: Without post-increment, the pointer outputs equal the pointer inputs.
- R8: `byte_valid_o` is high for exactly the one cycle after `mem_rd_o`, and `byte_o` carries the selected byte in that cycle.
- R9: A start in the cycle when `mem_rd_o` is high is ignored: it causes no further read and no further valid strobe.
- R10: Under reset (`rst_n`=0), `mem_rd_o` and `byte_valid_o` are low and `mem_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request one byte fetch |
| ext_mode_i | input | 1 | 1: prepend page register to the address |
| post_inc_i | input | 1 | 1: advance the pointer after the read |
| ptr_lo_i | input | 16 | Low byte pointer |
| ptr_pg_i | input | 8 | Page extension register |
| mem_word_i | input | 16 | Read data from memory, one cycle after read enable |
| mem_addr_o | output | 23 | Word address to memory |
| mem_rd_o | output | 1 | Read enable to memory |
| byte_o | output | 8 | Fetched byte, meaningful with `byte_valid_o` |
| byte_valid_o | output | 1 | Result strobe |
| ptr_lo_o | output | 16 | Updated low pointer, meaningful with `byte_valid_o` |
| ptr_pg_o | output | 8 | Updated page register, meaningful with `byte_valid_o` |

## Verification
The hardest situation to reach is a post-increment carry that crosses out of the low pointer into the page register. Random pointers almost never land on 0xFFFF, and even then the page has to wrap at 0xFF for the full roll-over to show. Directed fetches therefore place the pointer at 0xFFFF in both modes, with page values of 0x03 and 0xFF. A start issued in the same cycle as a read is also forced deliberately, to prove it is dropped. Random fetches from a fixed seed then cover lane selection, mode mixing and address formation.

// File: rtl/pfu_pkg.sv
// Shared constants and helper for the program memory byte fetch unit.
// Assumes a 16-bit word memory and byte-granular pointers.
package pfu_pkg;
    localparam int PFU_PTR_W  = 16;   // low pointer width in bits
    localparam int PFU_PG_W   = 8;    // page extension width in bits
    localparam int PFU_BYTE_W = 8;    // returned data width
    localparam int PFU_WORD_W = 16;   // memory word width

    // Fetch context captured at acceptance.
    typedef struct packed {
        logic ext_mode;
        logic lane;
    } pfu_ctx_t;
endpackage

// File: rtl/pfu_addr_gen.sv
// Address former and pointer advancer. Purely combinational.
// It splits the byte pointer into word address and lane, and computes the
// advanced pointer for either mode. It assumes PTR_W >= 2.
module pfu_addr_gen #(
    parameter int PTR_W = pfu_pkg::PFU_PTR_W,
    parameter int PG_W  = pfu_pkg::PFU_PG_W,
    localparam int WA_W = PG_W + PTR_W - 1,
    localparam int FL_W = PG_W + PTR_W
) (
    input  logic [PTR_W-1:0] ptr_lo,
    input  logic [PG_W-1:0]  ptr_pg,
    input  logic             ext_mode,
    input  logic             post_inc,
    output logic [WA_W-1:0]  word_addr,
    output logic             lane,
    output logic [PTR_W-1:0] nxt_lo,
    output logic [PG_W-1:0]  nxt_pg
);
    logic [FL_W-1:0]  full_inc;
    logic [PTR_W-1:0] lo_inc;
    logic [PG_W-1:0]  pg_part;

    // Select page bits of the address: zero in plain mode.
    always_comb pg_part = ext_mode ? ptr_pg : '0;

    // Form word address and byte lane.
    always_comb begin
        word_addr = {pg_part, ptr_lo[PTR_W-1:1]};
        lane      = ptr_lo[0];
    end

    // Wide and narrow incrementers.
    always_comb begin
        full_inc = {ptr_pg, ptr_lo} + {{(FL_W-1){1'b0}}, 1'b1};
        lo_inc   = ptr_lo + {{(PTR_W-1){1'b0}}, 1'b1};
    end

    // Choose the advanced pointer by mode.
    always_comb begin
        if (!post_inc) begin
            nxt_lo = ptr_lo;
            nxt_pg = ptr_pg;
        end else if (ext_mode) begin
            nxt_lo = full_inc[PTR_W-1:0];
            nxt_pg = full_inc[FL_W-1:PTR_W];
        end else begin
            nxt_lo = lo_inc;
            nxt_pg = ptr_pg;
        end
    end
endmodule

// File: rtl/pfu_ctrl.sv
// Sequencer for one fetch: accept, read strobe, result strobe.
// It assumes the memory returns data one cycle after the read enable.
// A start while the read strobe is high is dropped.
module pfu_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic rd,
    output logic valid
);
    // Accept a start only when no read is outstanding.
    always_comb accept = start && !rd;

    // Read strobe follows acceptance, valid follows read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd    <= 1'b0;
            valid <= 1'b0;
        end else begin
            rd    <= accept;
            valid <= rd;
        end
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !rd); // R9
    AST_VALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> valid); // R8
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(rd)); // R8
endmodule

// File: rtl/pfu_byte_sel.sv
// Byte lane multiplexer on the memory read word.
// It assumes the word width is a whole number of bytes; the lane index picks one.
module pfu_byte_sel #(
    parameter int BYTE_W = pfu_pkg::PFU_BYTE_W,
    parameter int WORD_W = pfu_pkg::PFU_WORD_W,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] lane_v [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Slice lane g.
        always_comb lane_v[g] = word[g*BYTE_W +: BYTE_W];
    end

    // Pick the requested lane.
    always_comb begin
        byte_out = lane_v[0];
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) byte_out = lane_v[i];
        end
    end
endmodule

// File: rtl/prog_byte_fetch.sv
// Program memory byte fetch unit (top).
// It reads one byte from 16-bit-word program memory with one cycle of latency.
// It assumes the memory samples mem_addr_o on the edge where mem_rd_o is high
// and presents mem_word_i until the next read.
module prog_byte_fetch #(
    parameter int PTR_W  = pfu_pkg::PFU_PTR_W,
    parameter int PG_W   = pfu_pkg::PFU_PG_W,
    parameter int BYTE_W = pfu_pkg::PFU_BYTE_W,
    parameter int WORD_W = pfu_pkg::PFU_WORD_W,
    localparam int WA_W  = PG_W + PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ext_mode_i,
    input  logic              post_inc_i,
    input  logic [PTR_W-1:0]  ptr_lo_i,
    input  logic [PG_W-1:0]   ptr_pg_i,
    input  logic [WORD_W-1:0] mem_word_i,
    output logic [WA_W-1:0]   mem_addr_o,
    output logic              mem_rd_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic [PTR_W-1:0]  ptr_lo_o,
    output logic [PG_W-1:0]   ptr_pg_o
);
    import pfu_pkg::*;

    logic             accept;
    logic [WA_W-1:0]  word_addr;
    logic             lane;
    logic [PTR_W-1:0] nxt_lo;
    logic [PG_W-1:0]  nxt_pg;
    pfu_ctx_t         ctx_q;

    pfu_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .accept (accept),
        .rd     (mem_rd_o),
        .valid  (byte_valid_o)
    );

    pfu_addr_gen #(.PTR_W(PTR_W), .PG_W(PG_W)) i_addr (
        .ptr_lo    (ptr_lo_i),
        .ptr_pg    (ptr_pg_i),
        .ext_mode  (ext_mode_i),
        .post_inc  (post_inc_i),
        .word_addr (word_addr),
        .lane      (lane),
        .nxt_lo    (nxt_lo),
        .nxt_pg    (nxt_pg)
    );

    // Capture address, lane, mode and advanced pointer on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            ctx_q      <= '0;
            ptr_lo_o   <= '0;
            ptr_pg_o   <= '0;
        end else if (accept) begin
            mem_addr_o     <= word_addr;
            ctx_q.lane     <= lane;
            ctx_q.ext_mode <= ext_mode_i;
            ptr_lo_o       <= nxt_lo;
            ptr_pg_o       <= nxt_pg;
        end
    end

    pfu_byte_sel #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_sel (
        .word     (mem_word_i),
        .sel      (ctx_q.lane),
        .byte_out (byte_o)
    );

    AST_PLAIN_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !ctx_q.ext_mode) |-> (mem_addr_o[WA_W-1:PTR_W-1] == '0)); // R3
    AST_EXT_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && ctx_q.ext_mode) |-> (mem_addr_o[WA_W-1:PTR_W-1] == $past(ptr_pg_i))); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $stable(mem_addr_o)); // R1
endmodule

// File: tb/test_prog_byte_fetch.sv
module test_prog_byte_fetch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, ext_mode_i, post_inc_i;
    logic [15:0] ptr_lo_i;
    logic [7:0]  ptr_pg_i;
    logic [15:0] mem_word_i;
    logic [22:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic [15:0] ptr_lo_o;
    logic [7:0]  ptr_pg_o;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;   // 50 MHz

    prog_byte_fetch i_prog_byte_fetch (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_mode_i(ext_mode_i),
        .post_inc_i(post_inc_i), .ptr_lo_i(ptr_lo_i), .ptr_pg_i(ptr_pg_i),
        .mem_word_i(mem_word_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .byte_o(byte_o), .byte_valid_o(byte_valid_o),
        .ptr_lo_o(ptr_lo_o), .ptr_pg_o(ptr_pg_o)
    );

    function automatic logic [15:0] mem_fn(input logic [22:0] a);
        return a[15:0] ^ {a[22:16], a[22:16], 2'b01} ^ 16'hA5C3;
    endfunction

    // Synchronous memory model, one cycle latency.
    always @(posedge clk) begin
        if (mem_rd_o) mem_word_i <= mem_fn(mem_addr_o);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One fetch; dup_start asserts start again during the read cycle (R9).
    task automatic fetch(input logic [15:0] z, input logic [7:0] pg, input logic ext,
                         input logic inc, input logic dup_start);
        logic [22:0] exp_addr;
        logic [15:0] w;
        logic [23:0] full;
        logic [15:0] exp_lo;
        logic [7:0]  exp_pg;
        exp_addr = {ext ? pg : 8'h00, z[15:1]};
        w = mem_fn(exp_addr);
        full = {pg, z} + 24'd1;
        if (!inc) begin exp_lo = z; exp_pg = pg; end                 // R7
        else if (ext) begin exp_lo = full[15:0]; exp_pg = full[23:16]; end // R6
        else begin exp_lo = z + 16'd1; exp_pg = pg; end              // R5
        @(negedge clk);
        start_i = 1'b1; ptr_lo_i = z; ptr_pg_i = pg; ext_mode_i = ext; post_inc_i = inc;
        @(negedge clk);
        start_i = dup_start;
        ptr_lo_i = ~z; ptr_pg_i = ~pg;
        check("R1 rd", {31'd0, mem_rd_o}, 32'd1);
        check("R1 word addr", {17'd0, mem_addr_o[14:0]}, {17'd0, z[15:1]});
        if (ext) check("R4 page addr", {24'd0, mem_addr_o[22:15]}, {24'd0, pg});
        else     check("R3 page addr", {24'd0, mem_addr_o[22:15]}, 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 valid", {31'd0, byte_valid_o}, 32'd1);
        check("R2 byte", {24'd0, byte_o}, {24'd0, z[0] ? w[15:8] : w[7:0]});
        check("R1 rd drop", {31'd0, mem_rd_o}, 32'd0);
        check("R5R6R7 lo", {16'd0, ptr_lo_o}, {16'd0, exp_lo});
        check("R5R6R7 pg", {24'd0, ptr_pg_o}, {24'd0, exp_pg});
        @(negedge clk);
        check("R8 valid width", {31'd0, byte_valid_o}, 32'd0);
        if (dup_start) check("R9 ignored start", {31'd0, mem_rd_o}, 32'd0);
    endtask

    initial begin
        start_i = 0; ext_mode_i = 0; post_inc_i = 0; ptr_lo_i = 0; ptr_pg_i = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 rd", {31'd0, mem_rd_o}, 32'd0);
        check("R10 valid", {31'd0, byte_valid_o}, 32'd0);
        check("R10 addr", {9'd0, mem_addr_o}, 32'd0);
        rst_n = 1'b1;
        // Directed corners.
        fetch(16'h1234, 8'h77, 1'b0, 1'b0, 1'b0);  // R2 low lane, R3
        fetch(16'h1235, 8'h77, 1'b1, 1'b0, 1'b0);  // R2 high lane, R4
        fetch(16'hFFFF, 8'h03, 1'b0, 1'b1, 1'b0);  // R5 wrap without carry
        fetch(16'hFFFF, 8'h03, 1'b1, 1'b1, 1'b0);  // R6 carry into page
        fetch(16'hFFFF, 8'hFF, 1'b1, 1'b1, 1'b0);  // R6 full roll-over
        fetch(16'h00FE, 8'h12, 1'b1, 1'b1, 1'b1);  // R9 start during read
        fetch(16'h8001, 8'hA0, 1'b0, 1'b0, 1'b1);  // R9, R7
        // Random fetches.
        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            fetch($urandom & 16'hFFFF, $urandom & 8'hFF, $urandom & 1,
                  $urandom & 1, ($urandom % 8) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule